// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive side of a network controller. It moves incoming frames into host memory through a circular ring of packet descriptors. Software sets the ring's base word address and its descriptor count through register writes. It then releases descriptors to the engine by moving a tail index forward. The engine owns a head index. Head marks the first descriptor it may fill, and tail marks the first descriptor it may not fill.

Bytes arrive on a valid/ready stream, and the final byte of each frame is flagged. The engine holds one whole frame in a local buffer. When the last byte arrives and the ring has a free descriptor, the engine does the following in order:

- reads the descriptor at head;
- copies the frame into the buffer that the descriptor names, packed four bytes per word;
- writes back a status word that carries the stored length, a filled flag and a truncation flag;
- advances head and pulses an interrupt.

When no descriptor is free, the frame is thrown away and a drop counter counts it. Memory is reached through a single request/acknowledge port, and each access moves one 32-bit word.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, head, tail and the drop count read 0, irq is 0, memReq is 0 and inReady is 1.
- R2: Register write addresses are 0 = ring base word address, 1 = descriptor count, 2 = tail. Read addresses are 0 = head, 1 = tail, 2 = drop count, 3 = base. Writing the descriptor count also sets head and tail to 0.
- R3: A register write has no effect unless the engine is idle, meaning no byte of a frame has been taken and no memory phase is running.
- R4: Descriptor i lives at two words starting at base + 2*i. Word 0 holds the buffer word address. Bits [15:0] of word 1 hold the buffer length in bytes.
- R5: For each stored frame the memory accesses come in this order: read word 0, read word 1, write the data words, write the status word to word 1. While memReq is high and memAck is low, the request, its address and its write flag are held unchanged.
- R6: Frame byte k is written to bits [8*(k%4)+7 : 8*(k%4)] of word ptr + k/4. Byte lanes past the stored length in the last word are 0, and no word past the stored data is written.
- R7: The status word holds the stored byte count in bits [15:0], 1 in bit 16 (filled flag) and the truncation flag in bit 17. All other bits are 0.
- R8: After the status write is acknowledged, head becomes (head+1) mod count. irq is high for exactly one cycle, and that cycle is the first one in which head reads the new value.
- R9: If head equals tail when a frame's last byte is taken, the frame is dropped. No memory access takes place, head does not change, no irq is raised, and the drop count rises by exactly 1.
- R10: The stored length is the minimum of the frame length, the buffer length and MAX_FRAME. The truncation flag is 1 exactly when the stored length is less than the frame length. A buffer length of 0 gives a status-only write.
- R11: inReady is 1 while idle and while a frame is being received. It is 0 from the cycle after a stored frame's last byte until the cycle head advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Register write address |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 2 | Register read address |
| regRdData | output | 32 | Register read data (combinational) |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Marks the last byte of a frame |
| inReady | output | 1 | Engine can take a byte |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | AW | Memory word address |
| memWData | output | 32 | Write data |
| memAck | input | 1 | Request completed; read data valid |
| memRData | input | 32 | Read data |
| irq | output | 1 | One-cycle frame-stored pulse |

## Verification
The bench targets the cases where a frame meets a full ring:

- The ring is full at the moment a frame ends. A design that checked fullness too late would write over a descriptor software still owns. A design that counted drops wrongly would report a wrong drop total.
- Truncation is tested against short, zero-length and exact-fit buffers. An off-by-one in the length clamp shows up as a wrong stored count, a missing error flag, or a clobbered word just past the data.
- A tail write is issued while the frame is being written. Head wraparound is exercised across many random frames. Either bug would show up as a wrong head or tail read-back.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  localparam int LENW     = 16;   // byte-count field width in the status word
  localparam int DW       = 32;   // memory and register data width
  localparam int FLAG_BIT = 16;   // filled flag position in the status word
  localparam int ERR_BIT  = 17;   // truncation flag position in the status word

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_RDPTR,
    ST_RDLEN,
    ST_WRDATA,
    ST_WRSTAT
  } rxState_e;

  typedef enum logic [1:0] {
    MS_PTR,
    MS_LEN,
    MS_DATA,
    MS_STAT
  } memSel_e;

  typedef struct packed {
    logic    acceptByte;
    logic    regOpen;
    logic    capPtr;
    logic    capLen;
    logic    wordAdv;
    logic    finishFrame;
    logic    dropFrame;
    logic    memReq;
    memSel_e memSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        memAck,
  input  logic        ringFull,
  input  logic        dataDone,
  output logic        inReady,
  output ctrlStrobe_t strobe
);

  rxState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inReady = (state == ST_IDLE) || (state == ST_RECV);

  always_comb begin
    strobe        = '0;
    strobe.memSel = MS_PTR;
    stateNext     = state;
    unique case (state)
      ST_IDLE, ST_RECV: begin
        strobe.regOpen = (state == ST_IDLE);
        if (inValid) begin
          strobe.acceptByte = 1'b1;
          if (inLast) begin
            if (ringFull) begin
              strobe.dropFrame = 1'b1;
              stateNext        = ST_IDLE;
            end else begin
              stateNext = ST_RDPTR;
            end
          end else begin
            stateNext = ST_RECV;
          end
        end
      end
      ST_RDPTR: begin
        strobe.memReq = 1'b1;
        strobe.memSel = MS_PTR;
        if (memAck) begin
          strobe.capPtr = 1'b1;
          stateNext     = ST_RDLEN;
        end
      end
      ST_RDLEN: begin
        strobe.memReq = 1'b1;
        strobe.memSel = MS_LEN;
        if (memAck) begin
          strobe.capLen = 1'b1;
          stateNext     = ST_WRDATA;
        end
      end
      ST_WRDATA: begin
        strobe.memSel = MS_DATA;
        if (dataDone) begin
          stateNext = ST_WRSTAT;
        end else begin
          strobe.memReq = 1'b1;
          if (memAck) strobe.wordAdv = 1'b1;
        end
      end
      ST_WRSTAT: begin
        strobe.memReq = 1'b1;
        strobe.memSel = MS_STAT;
        if (memAck) begin
          strobe.finishFrame = 1'b1;
          stateNext          = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rx_ring_datapath.sv
module rx_ring_datapath
  import rx_ring_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAX_DESC  = 16,
  parameter int MAX_FRAME = 64,
  localparam int IDXW     = $clog2(MAX_DESC),
  localparam int SZW      = IDXW + 1
)(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic            regWrEn,
  input  logic [1:0]      regWrAddr,
  input  logic [DW-1:0]   regWrData,
  input  logic [1:0]      regRdAddr,
  output logic [DW-1:0]   regRdData,
  input  logic [7:0]      inData,
  input  logic [DW-1:0]   memRData,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWData,
  output logic            memWe,
  output logic            irq,
  output logic            ringFull,
  output logic            dataDone,
  output logic [IDXW-1:0] headIdx,
  output logic [IDXW-1:0] tailIdx,
  output logic [DW-1:0]   dropCnt
);

  localparam int BIDXW = $clog2(MAX_FRAME);

  logic [AW-1:0]   baseReg;
  logic [SZW-1:0]  sizeReg;
  logic [IDXW-1:0] headReg, tailReg, headNext;
  logic [DW-1:0]   dropReg;
  logic [AW-1:0]   bufPtr;
  logic [LENW-1:0] bufLen, rxTotal, wordIdx;
  logic [LENW-1:0] capLimit, storeLen, numWords;
  logic            truncErr, irqReg;
  logic [7:0]      frameMem [MAX_FRAME];
  logic [DW-1:0]   dataWord, statWord;
  logic [AW-1:0]   descAddr;
  logic            unusedBits;

  assign unusedBits = ^{regWrData, memRData};

  // ring index arithmetic
  always_comb begin
    logic [SZW-1:0] inc;
    inc      = {1'b0, headReg} + SZW'(1);
    headNext = (inc >= sizeReg) ? '0 : inc[IDXW-1:0];
  end

  assign ringFull = (headReg == tailReg);
  assign descAddr = baseReg + AW'({headReg, 1'b0});

  // length clamp and word count
  assign capLimit = (bufLen < LENW'(MAX_FRAME)) ? bufLen : LENW'(MAX_FRAME);
  assign storeLen = (rxTotal < capLimit) ? rxTotal : capLimit;
  assign truncErr = (rxTotal > storeLen);
  assign numWords = (storeLen + LENW'(3)) >> 2;
  assign dataDone = (wordIdx >= numWords);

  // packed data word with zeroed lanes past the stored length
  always_comb begin : packWord
    logic [LENW-1:0] bIdx;
    dataWord = '0;
    for (int k = 0; k < 4; k++) begin
      bIdx = {wordIdx[LENW-3:0], 2'(k)};
      if (bIdx < storeLen) dataWord[8*k +: 8] = frameMem[bIdx[BIDXW-1:0]];
    end
  end

  always_comb begin
    statWord                = '0;
    statWord[LENW-1:0]      = storeLen;
    statWord[FLAG_BIT]      = 1'b1;
    statWord[ERR_BIT]       = truncErr;
  end

  // memory address and data selection
  always_comb begin
    unique case (strobe.memSel)
      MS_PTR:  begin memAddr = descAddr;              memWData = '0;       end
      MS_LEN:  begin memAddr = descAddr + AW'(1);     memWData = '0;       end
      MS_DATA: begin memAddr = bufPtr + AW'(wordIdx); memWData = dataWord; end
      default: begin memAddr = descAddr + AW'(1);     memWData = statWord; end
    endcase
  end

  assign memWe = (strobe.memSel == MS_DATA) || (strobe.memSel == MS_STAT);

  // local frame buffer
  always_ff @(posedge clk) begin
    if (strobe.acceptByte && (rxTotal < LENW'(MAX_FRAME)))
      frameMem[rxTotal[BIDXW-1:0]] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      sizeReg <= SZW'(MAX_DESC);
      headReg <= '0;
      tailReg <= '0;
      dropReg <= '0;
      bufPtr  <= '0;
      bufLen  <= '0;
      rxTotal <= '0;
      wordIdx <= '0;
      irqReg  <= 1'b0;
    end else begin
      irqReg <= strobe.finishFrame;
      if (strobe.regOpen && regWrEn) begin
        unique case (regWrAddr)
          2'd0: baseReg <= regWrData[AW-1:0];
          2'd1: begin
            sizeReg <= regWrData[SZW-1:0];
            headReg <= '0;
            tailReg <= '0;
          end
          2'd2: tailReg <= regWrData[IDXW-1:0];
          default: ;
        endcase
      end
      if (strobe.acceptByte && (rxTotal != '1)) rxTotal <= rxTotal + LENW'(1);
      if (strobe.capPtr) bufPtr <= memRData[AW-1:0];
      if (strobe.capLen) begin
        bufLen  <= memRData[LENW-1:0];
        wordIdx <= '0;
      end
      if (strobe.wordAdv) wordIdx <= wordIdx + LENW'(1);
      if (strobe.finishFrame) begin
        headReg <= headNext;
        rxTotal <= '0;
      end
      if (strobe.dropFrame) begin
        dropReg <= dropReg + DW'(1);
        rxTotal <= '0;
      end
    end
  end

  always_comb begin
    unique case (regRdAddr)
      2'd0:    regRdData = DW'(headReg);
      2'd1:    regRdData = DW'(tailReg);
      2'd2:    regRdData = dropReg;
      default: regRdData = DW'(baseReg);
    endcase
  end

  assign irq     = irqReg;
  assign headIdx = headReg;
  assign tailIdx = tailReg;
  assign dropCnt = dropReg;

endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rx_ring_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAX_DESC  = 16,
  parameter int MAX_FRAME = 64
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [1:0]    regWrAddr,
  input  logic [DW-1:0] regWrData,
  input  logic [1:0]    regRdAddr,
  output logic [DW-1:0] regRdData,
  input  logic          inValid,
  input  logic [7:0]    inData,
  input  logic          inLast,
  output logic          inReady,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWData,
  input  logic          memAck,
  input  logic [DW-1:0] memRData,
  output logic          irq
);

  localparam int IDXW = $clog2(MAX_DESC);

  ctrlStrobe_t     strobe;
  logic            ringFull, dataDone;
  logic [IDXW-1:0] headIdx, tailIdx;
  logic [DW-1:0]   dropCnt;

  rx_ring_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .memAck   (memAck),
    .ringFull (ringFull),
    .dataDone (dataDone),
    .inReady  (inReady),
    .strobe   (strobe)
  );

  rx_ring_datapath #(
    .AW        (AW),
    .MAX_DESC  (MAX_DESC),
    .MAX_FRAME (MAX_FRAME)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .regRdAddr (regRdAddr),
    .regRdData (regRdData),
    .inData    (inData),
    .memRData  (memRData),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .memWe     (memWe),
    .irq       (irq),
    .ringFull  (ringFull),
    .dataDone  (dataDone),
    .headIdx   (headIdx),
    .tailIdx   (tailIdx),
    .dropCnt   (dropCnt)
  );

  assign memReq = strobe.memReq;

endmodule

// File: rtl/rx_ring_engine_checker.sv
module rx_ring_engine_checker #(
  parameter int AW   = 16,
  parameter int IDXW = 4
)(
  input logic            clk,
  input logic            rstN,
  input logic            irq,
  input logic            inReady,
  input logic            memReq,
  input logic            memAck,
  input logic            memWe,
  input logic [AW-1:0]   memAddr,
  input logic            regWrEn,
  input logic [IDXW-1:0] headIdx,
  input logic [IDXW-1:0] tailIdx,
  input logic [31:0]     dropCnt
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R5

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R8

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !$past(regWrEn)) |-> $stable(headIdx)); // R8

  AST_NO_FILL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(headIdx) != tailIdx)); // R9

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dropCnt == $past(dropCnt)) || (dropCnt == $past(dropCnt) + 32'd1)); // R9

  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !inReady); // R11

endmodule

bind rx_ring_engine rx_ring_engine_checker #(
  .AW   (AW),
  .IDXW (IDXW)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .irq     (irq),
  .inReady (inReady),
  .memReq  (memReq),
  .memAck  (memAck),
  .memWe   (memWe),
  .memAddr (memAddr),
  .regWrEn (regWrEn),
  .headIdx (headIdx),
  .tailIdx (tailIdx),
  .dropCnt (dropCnt)
);

// File: tb/rx_ring_engine_test.sv
module rx_ring_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int NDESC      = 8;
  localparam int MAXF       = 64;
  localparam int BASE       = 16;
  localparam int BUFFILL    = 20;
  localparam logic [31:0] FILLPAT = 32'hA5A5A5A5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [1:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic        memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0] memWData;
  logic        memAck = 1'b0;
  logic [31:0] memRData = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;
  int mHead = 0, mTail = 0, mDrop = 0, mSize = NDESC;

  logic [31:0] mem [0:1023];
  logic [7:0]  frameBytes [0:127];

  rx_ring_engine #(.AW(AW), .MAX_DESC(16), .MAX_FRAME(MAXF)) uut (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inReady(inReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memAck(memAck), .memRData(memRData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: acknowledge after a random wait
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck && ($urandom % 3 != 0)) begin
        memAck <= 1'b1;
        if (memWe) mem[memAddr[9:0]] <= memWData;
        else       memRData <= mem[memAddr[9:0]];
      end
    end
  end

  always @(posedge clk) if (rstN && irq) irqCount++;

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  function automatic int bufAddr(int i);
    return 256 + 32 * i;
  endfunction

  function automatic int minOf(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic regWrite(int a, int d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = 2'(a); regWrData = 32'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(int a, output logic [31:0] v);
    regRdAddr = 2'(a);
    #1;
    v = regRdData;
  endtask

  task automatic setupDesc(int i, int blen);
    mem[BASE + 2*i]     = 32'(bufAddr(i));
    mem[BASE + 2*i + 1] = 32'(blen);
    for (int w = 0; w < BUFFILL; w++) mem[bufAddr(i) + w] = FILLPAT;
  endtask

  task automatic sendFrame(int len);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      frameBytes[i] = 8'($urandom);
      inValid = 1'b1; inData = frameBytes[i]; inLast = (i == len - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic runFrame(int len, int blen, bit busyWrite, string tag);
    logic [31:0] v, expW;
    int full, slot, stored, nw, irqBefore, waited;
    bit ok;
    full = (mHead == mTail);
    slot = mHead;
    if (!full) setupDesc(slot, blen);
    else mem[BASE + 2*slot + 1] = 32'(blen);
    irqBefore = irqCount;
    sendFrame(len);
    if (full) begin
      mDrop++;
      checkEq({tag, " R9 ready after drop"}, 32'(inReady), 32'd1);
      repeat (3) @(negedge clk);
      regRead(2, v); checkEq({tag, " R9 drop count"}, v, 32'(mDrop));
      regRead(0, v); checkEq({tag, " R9 head kept"}, v, 32'(mHead));
      checkEq({tag, " R9 no irq"}, 32'(irqCount), 32'(irqBefore));
      checkEq({tag, " R9 desc untouched"}, mem[BASE + 2*slot + 1], 32'(blen));
      return;
    end
    checkEq({tag, " R11 ready low busy"}, 32'(inReady), 32'd0);
    if (busyWrite) regWrite(2, (mTail + 3) % mSize);
    waited = 0;
    while (!irq && waited < 400) begin @(negedge clk); waited++; end
    checkEq({tag, " R8 irq seen"}, 32'(irq), 32'd1);
    mHead = (mHead + 1) % mSize;
    regRead(0, v); checkEq({tag, " R8 head advanced"}, v, 32'(mHead));
    checkEq({tag, " R11 ready back"}, 32'(inReady), 32'd1);
    @(negedge clk);
    checkEq({tag, " R8 irq one cycle"}, 32'(irq), 32'd0);
    if (busyWrite) begin
      regRead(1, v); checkEq({tag, " R3 busy tail write ignored"}, v, 32'(mTail));
    end
    stored = minOf(minOf(len, blen), MAXF);
    nw = (stored + 3) / 4;
    ok = 1'b1;
    for (int w = 0; w < nw; w++) begin
      expW = '0;
      for (int k = 0; k < 4; k++)
        if (4*w + k < stored) expW[8*k +: 8] = frameBytes[4*w + k];
      if (mem[bufAddr(slot) + w] !== expW) begin
        ok = 1'b0;
        $display("FAIL %s R6 word %0d: actual %0h expected %0h", tag, w,
                 mem[bufAddr(slot) + w], expW);
      end
    end
    checkEq({tag, " R6 data words"}, 32'(ok), 32'd1);
    checkEq({tag, " R10 no write past data"}, mem[bufAddr(slot) + nw], FILLPAT);
    expW = 32'(stored) | (32'd1 << 16) | ((len > stored) ? (32'd1 << 17) : 32'd0);
    checkEq({tag, " R7 R10 status word"}, mem[BASE + 2*slot + 1], expW);
    checkEq({tag, " R4 pointer word kept"}, mem[BASE + 2*slot], 32'(bufAddr(slot)));
  endtask

  initial begin
    logic [31:0] v;
    int dummy, freeCnt, adv;
    dummy = $urandom(32'd20240611);
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 inReady", 32'(inReady), 32'd1);
    checkEq("R1 irq", 32'(irq), 32'd0);
    checkEq("R1 memReq", 32'(memReq), 32'd0);
    regRead(0, v); checkEq("R1 head", v, 32'd0);
    regRead(1, v); checkEq("R1 tail", v, 32'd0);
    regRead(2, v); checkEq("R1 drops", v, 32'd0);
    // R2 programming
    regWrite(0, BASE);
    regWrite(1, NDESC);
    regRead(3, v); checkEq("R2 base readback", v, 32'(BASE));
    // ring full at start: drop
    runFrame(12, 64, 1'b0, "dropAtStart");
    regWrite(2, 7); mTail = 7;
    regRead(1, v); checkEq("R2 tail readback", v, 32'd7);
    runFrame(10, 64, 1'b0, "basic");
    runFrame(1, 64, 1'b0, "singleByte");
    runFrame(70, 64, 1'b0, "R10 overLong");
    runFrame(20, 13, 1'b0, "R10 shortBuf");
    runFrame(9, 0, 1'b0, "R10 zeroBuf");
    runFrame(4, 4, 1'b0, "exactFit");
    runFrame(17, 64, 1'b1, "R3 busyWrite");
    // ring now full (head caught tail): drop
    runFrame(5, 64, 1'b0, "R9 fullAgain");
    // random traffic with wraparound and software releases
    for (int it = 0; it < 40; it++) begin
      freeCnt = (mTail - mHead + mSize) % mSize;
      if ($urandom % 2 == 0) begin
        adv = $urandom % ((mSize - 1 - freeCnt) + 1);
        if (adv > 0) begin
          mTail = (mTail + adv) % mSize;
          regWrite(2, mTail);
        end
      end
      runFrame(1 + ($urandom % 80), $urandom % 65, 1'b0, "random");
    end
    // R2 size write resets head and tail
    regWrite(1, 4);
    regRead(0, v); checkEq("R2 size write head", v, 32'd0);
    regRead(1, v); checkEq("R2 size write tail", v, 32'd0);
    summary();
  end

endmodule